// File: doc/BRIEF.md
# Bridge Control Register File

This block is a bank of 32-bit control registers for a host bridge. It sits behind a simple memory-mapped bus that carries one full-word read or write per cycle. Bits [6:2] of the byte offset pick the word, and the two low bits are ignored. Most words are plain storage. Each plain word resets to a defined value and returns what was last written to it.

Three registers behave differently. The interrupt-enable word cannot be written directly. It changes only through two alias words: writing one of them sets bits in the enable word, and writing the other clears bits in it. The general configuration word has a self-reset bit. When a write moves that bit from 0 to 1, the bank raises a one-cycle system reset request. The interrupt edge-select word and the polarity word are also driven out as vectors, so that the interrupt routing logic can use them without a bus access.

Top module: `bridge_ctrl_regs`

## Requirements
- R1: A word is selected by byte-offset bits [6:2]. Offset bits [1:0] have no effect on which word is read or written.
- R2: A write to a plain storage word stores the whole 32-bit value. A later read of that word returns the value.
- R3: A write to the set alias (offset 0x30) stores the value in the alias word. It also ORs the value into the enable word (offset 0x38).
- R4: A write to the clear alias (offset 0x34) stores the value in the alias word. It also clears, in the enable word, every bit that is 1 in the value.
- R5: Writes to the enable word (0x38) and to the status word (0x3C) are ignored. The status word always reads zero.
- R6: `reset_req` is high for exactly the one cycle after a write to offset 0x04 that changes bit 2 from 0 to 1. It stays low after any other write, including a write with bit 2 set while bit 2 is already 1.
- R7: After reset, the words hold these values:
  - 0x00 = 0x00000C40
  - 0x04 = 0x00001384
  - 0x08 = 0x2BFF8010
  - 0x0C = 0x255E0091
  - 0x10 = 0x00006140
  - 0x1C = 0x000001FF
  - 0x20 = 0x000001FF
  - 0x68 = 0x00000008
  - 0x6C = 0x10000000
  - every other word = 0
- R8: Writes to offsets 0x70 and above are ignored, and reads of those offsets return zero.
- R9: `irq_edge_sel` always equals the word at 0x24, and `irq_polarity` always equals the word at 0x2C.
- R10: A read presented in one cycle updates `bus_rdata` at that clock edge. `bus_rdata` holds its value through idle cycles and through write cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access request in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset into the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| reset_req | output | 1 | One-cycle system reset request |
| irq_edge_sel | output | 32 | Interrupt edge-select vector |
| irq_polarity | output | 32 | Interrupt polarity vector |

## Verification
Directed sequences come first.
- Every word is read back after reset, which shows whether each reset value is in place.
- The set and clear aliases are written with overlapping masks. This tells an OR-merge apart from an overwrite.
- The self-reset bit is written 1 while already 1, then 0, then 1. This separates a true 0-to-1 edge from a level test.

A seeded random run follows. It writes random data to offsets across the whole 8-bit space, with random low bits, and mixes in reads. This exposes decode slips between neighbouring words, leaks from offsets outside the window, and stale read data.

// File: rtl/bridge_ctrl_pkg.sv
package bridge_ctrl_pkg;
  localparam int DATA_W   = 32;
  localparam int NUM_REGS = 28;
  localparam int IDX_W    = $clog2(NUM_REGS);

  // word indices whose behaviour is special
  localparam int CFG_IDX   = 1;
  localparam int EDGE_IDX  = 9;
  localparam int POL_IDX   = 11;
  localparam int SET_IDX   = 12;
  localparam int CLR_IDX   = 13;
  localparam int EN_IDX    = 14;
  localparam int STAT_IDX  = 15;
  localparam int SRST_BIT  = 2;

  typedef logic [DATA_W-1:0] word_t;

  // word index from a byte offset (two low bits dropped)
  function automatic int unsigned word_of(input logic [7:0] off);
    return int'(off[7:2]);
  endfunction

  // reset value per word index
  function automatic word_t reset_value(input int idx);
    word_t v;
    case (idx)
      0:       v = 32'h0000_0C40;
      1:       v = (32'h1 << 2) | (32'h1 << 7) | (32'h1 << 8) | (32'h1 << 9) | (32'h1 << 12);
      2:       v = 32'h2BFF_8010;
      3:       v = 32'h255E_0091;
      4:       v = 32'h0000_6140;
      7, 8:    v = 32'h0000_01FF;
      26:      v = 32'h0000_0008;
      27:      v = 32'h1000_0000;
      default: v = '0;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/bridge_ctrl_decode.sv
module bridge_ctrl_decode
  import bridge_ctrl_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx,
  output logic              in_range
);
  localparam int WORD_BITS = ADDR_W - 2;

  logic [WORD_BITS-1:0] word_raw;

  assign word_raw = addr[ADDR_W-1:2];
  assign in_range = (int'(word_raw) < NUM_REGS);
  assign idx      = word_raw[IDX_W-1:0];
endmodule

// File: rtl/bridge_ctrl_enable.sv
module bridge_ctrl_enable
  import bridge_ctrl_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  set_wr,
  input  logic  clr_wr,
  input  word_t mask,
  output word_t en_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)      en_q <= reset_value(EN_IDX);
    else if (set_wr) en_q <= en_q | mask;
    else if (clr_wr) en_q <= en_q & ~mask;
  end

  AST_EN_SET_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    set_wr |=> ((en_q & $past(mask)) == $past(mask))); // R3
  AST_EN_CLR_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> ((en_q & $past(mask)) == '0)); // R4
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_wr || clr_wr) |=> $stable(en_q)); // R5
endmodule

// File: rtl/bridge_ctrl_srst.sv
module bridge_ctrl_srst (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_wr,
  input  logic old_bit,
  input  logic new_bit,
  output logic req_q
);
  logic rise_evt;

  assign rise_evt = cfg_wr && !old_bit && new_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= rise_evt;
  end

  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |=> !req_q); // R6
endmodule

// File: rtl/bridge_ctrl_regs.sv
module bridge_ctrl_regs
  import bridge_ctrl_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              reset_req,
  output logic [31:0]       irq_edge_sel,
  output logic [31:0]       irq_polarity
);
  logic [IDX_W-1:0] idx;
  logic             in_range;
  logic             wr_evt;
  logic             rd_evt;
  logic             set_wr;
  logic             clr_wr;
  logic             cfg_wr;
  word_t            en_q;
  word_t            reg_q [NUM_REGS];
  word_t            rdata_q;

  bridge_ctrl_decode #(.ADDR_W(ADDR_W)) dec_i (
    .addr     (bus_addr),
    .idx      (idx),
    .in_range (in_range)
  );

  assign wr_evt = bus_sel && bus_wr && in_range;
  assign rd_evt = bus_sel && !bus_wr;
  assign set_wr = wr_evt && (int'(idx) == SET_IDX);
  assign clr_wr = wr_evt && (int'(idx) == CLR_IDX);
  assign cfg_wr = wr_evt && (int'(idx) == CFG_IDX);

  bridge_ctrl_enable en_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_wr (set_wr),
    .clr_wr (clr_wr),
    .mask   (bus_wdata),
    .en_q   (en_q)
  );

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_word
    if (g == EN_IDX) begin : g_en
      assign reg_q[g] = en_q;
    end else if (g == STAT_IDX) begin : g_stat
      assign reg_q[g] = '0;
    end else begin : g_plain
      word_t q;
      always_ff @(posedge clk) begin
        if (!rst_n)                          q <= reset_value(g);
        else if (wr_evt && int'(idx) == g)   q <= bus_wdata;
      end
      assign reg_q[g] = q;
    end
  end

  bridge_ctrl_srst srst_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_wr  (cfg_wr),
    .old_bit (reg_q[CFG_IDX][SRST_BIT]),
    .new_bit (bus_wdata[SRST_BIT]),
    .req_q   (reset_req)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      rdata_q <= '0;
    else if (rd_evt) rdata_q <= in_range ? reg_q[idx] : '0;
  end

  assign bus_rdata    = rdata_q;
  assign irq_edge_sel = reg_q[EDGE_IDX];
  assign irq_polarity = reg_q[POL_IDX];

  AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_evt && !in_range) |=> (bus_rdata == '0)); // R8
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_evt |=> $stable(bus_rdata)); // R10
  AST_REQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reset_req) |-> ($past(cfg_wr) && $past(bus_wdata[SRST_BIT]))); // R6
  AST_STATUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_evt && in_range && int'(idx) == STAT_IDX) |=> (bus_rdata == '0)); // R5
endmodule

// File: tb/bridge_ctrl_regs_tb.sv
`timescale 1ns/1ps
module bridge_ctrl_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        reset_req;
  logic [31:0] irq_edge_sel;
  logic [31:0] irq_polarity;

  int checks = 0;
  int errors = 0;
  logic [31:0] mdl [28];
  logic        last_req;
  logic [31:0] last_rd;

  always #2 clk = ~clk;

  bridge_ctrl_regs dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .reset_req(reset_req), .irq_edge_sel(irq_edge_sel), .irq_polarity(irq_polarity)
  );

  function automatic logic [31:0] exp_reset(input int off);
    case (off)
      'h00: return 32'h0000_0C40;
      'h04: return 32'h0000_1384;
      'h08: return 32'h2BFF_8010;
      'h0C: return 32'h255E_0091;
      'h10: return 32'h0000_6140;
      'h1C: return 32'h0000_01FF;
      'h20: return 32'h0000_01FF;
      'h68: return 32'h0000_0008;
      'h6C: return 32'h1000_0000;
      default: return 32'h0;
    endcase
  endfunction

  // model write; returns expected reset request
  function automatic logic mdl_write(input logic [7:0] a, input logic [31:0] d);
    int w;
    logic rise;
    w = a / 4;
    rise = 1'b0;
    if (w >= 28 || w == 14 || w == 15) return 1'b0;
    if (w == 12) mdl[14] = mdl[14] | d;
    if (w == 13) mdl[14] = mdl[14] & ~d;
    if (w == 1) rise = (mdl[1][2] == 1'b0) && d[2];
    mdl[w] = d;
    return rise;
  endfunction

  function automatic logic [31:0] mdl_read(input logic [7:0] a);
    int w;
    w = a / 4;
    return (w >= 28) ? 32'h0 : mdl[w];
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    last_req = reset_req;
  endtask

  task automatic do_read(input logic [7:0] a);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    last_rd = bus_rdata;
  endtask

  task automatic wr_chk(input logic [7:0] a, input logic [31:0] d);
    logic er;
    er = mdl_write(a, d);
    do_write(a, d);
    check(last_req == er, "R6 reset_req after write", {31'b0, last_req}, {31'b0, er});
    check(irq_edge_sel == mdl[9], "R9 edge vector", irq_edge_sel, mdl[9]);
    check(irq_polarity == mdl[11], "R9 polarity vector", irq_polarity, mdl[11]);
  endtask

  task automatic rd_chk(input logic [7:0] a, input string tag);
    logic [31:0] e;
    e = mdl_read(a);
    do_read(a);
    check(last_rd == e, tag, last_rd, e);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%08h expected=%08h", 32'h1, 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd20240613));
    for (int i = 0; i < 28; i++) mdl[i] = exp_reset(i * 4);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(bus_rdata == 0, "R10 rdata after reset", bus_rdata, 0);
    check(reset_req == 1'b0, "R6 idle after reset", {31'b0, reset_req}, 0);
    // R7: every word after reset
    for (int i = 0; i < 28; i++) rd_chk(8'(i * 4), "R7 reset value");
    // R2 plain storage, R1 low bits ignored
    wr_chk(8'h40, 32'hDEAD_BEEF);
    rd_chk(8'h40, "R2 plain readback");
    wr_chk(8'h47, 32'h1234_5678);
    rd_chk(8'h44, "R1 low bits on write");
    rd_chk(8'h46, "R1 low bits on read");
    // R9 vectors
    wr_chk(8'h24, 32'hA5A5_0F0F);
    wr_chk(8'h2C, 32'h0FF0_1234);
    // R3 / R4 enable aliases
    wr_chk(8'h30, 32'h0000_00F0);
    wr_chk(8'h30, 32'h0000_0F00);
    rd_chk(8'h38, "R3 set ORs into enable");
    rd_chk(8'h30, "R3 set alias stored");
    wr_chk(8'h34, 32'h0000_0330);
    rd_chk(8'h38, "R4 clear removes bits");
    rd_chk(8'h34, "R4 clear alias stored");
    // R5 read-only words
    wr_chk(8'h38, 32'hFFFF_FFFF);
    rd_chk(8'h38, "R5 enable write ignored");
    wr_chk(8'h3C, 32'hFFFF_FFFF);
    rd_chk(8'h3C, "R5 status reads zero");
    // R6 self-reset edge
    wr_chk(8'h04, 32'h0000_1384);
    wr_chk(8'h04, 32'h0000_0000);
    wr_chk(8'h04, 32'h0000_0004);
    check(last_req == 1'b1, "R6 rising edge request", {31'b0, last_req}, 1);
    @(negedge clk);
    check(reset_req == 1'b0, "R6 single cycle", {31'b0, reset_req}, 0);
    // R8 outside window
    wr_chk(8'h70, 32'hFFFF_FFFF);
    wr_chk(8'hF0, 32'hFFFF_FFFF);
    rd_chk(8'h70, "R8 read beyond window");
    rd_chk(8'h00, "R8 word 0 untouched");
    rd_chk(8'h30, "R8 alias untouched");
    // R10 rdata holds through idle and writes
    rd_chk(8'h08, "R10 read");
    repeat (3) @(negedge clk);
    check(bus_rdata == mdl[2], "R10 hold idle", bus_rdata, mdl[2]);
    wr_chk(8'h0C, 32'h1111_2222);
    check(bus_rdata == mdl[2], "R10 hold over write", bus_rdata, mdl[2]);
    // random mix
    for (int n = 0; n < 600; n++) begin
      logic [7:0] a;
      logic [31:0] d;
      a = 8'($urandom_range(0, 255));
      d = $urandom();
      if ($urandom_range(0, 7) == 0) a = 8'h04;
      if ($urandom_range(0, 1) == 0) wr_chk(a, d);
      else rd_chk(a, "R2 random readback");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule